// File: doc/BRIEF.md
# Parallel ATA Strobe Timing Generator

This block produces the active-low read and write strobes of a parallel ATA channel for programmed-I/O data cycles and for task-file register cycles. Each attached device (two by default) owns one 32-bit packed timing word. The word holds the setup, active and recovery phase lengths for both cycle kinds, plus transfer-mode enable flags that are stored but do not shape the strobes. A requester raises `req` with the device, the cycle kind and the direction. The block then runs one bus cycle and answers with a one-clock `done` pulse.

Software or a mode-setting engine updates a timing word through a masked configuration port. A write names a transfer class, and only the bits that belong to that class are replaced, so the other fields of the word are kept. This lets PIO, multiword-DMA and ultra-DMA timings be programmed into one shared word one after another without losing the others.

The controller has five states. IDLE waits for a request. SETUP holds both strobes inactive for the setup time. ACTIVE drives one strobe low. RECOVER holds both strobes inactive for the recovery time. HANDOFF is a one-clock window after `done`. The transitions are:
- IDLE→SETUP when a request is seen.
- SETUP→ACTIVE when the setup count expires.
- ACTIVE→RECOVER when the active count expires.
- RECOVER→HANDOFF when the recovery count expires, which is the clock in which `done` is high.
- HANDOFF→ACTIVE when the request is still high (a back-to-back cycle, with no setup).
- HANDOFF→IDLE when the request is low.

Top module: `pata_strobe_gen`

## Requirements
- R1: After reset both strobes are high, `done` is low, and every device word holds `RESET_WORD` (default 0x06814EA7), which sets the first cycle's timing.
- R2: A data cycle (`req_tf`=0) holds its strobe low for word bits [8:4]+1 clocks and then inactive for bits [3:0]+1 clocks, with `done` in the last of those inactive clocks.
- R3: A task-file cycle (`req_tf`=1) holds its strobe low for bits [17:13]+1 clocks and recovers for bits [12:9]+1 clocks.
- R4: A cycle started from IDLE is preceded by one idle clock plus a setup phase of bits [24:22]+1 clocks (data) or bits [27:25]+1 clocks (task-file).
- R5: If `req` is high in the clock after `done`, the next cycle's strobe falls on the following clock, with no setup phase.
- R6: `req_wr`=1 pulses only `wr_n`, `req_wr`=0 pulses only `rd_n`, and the two strobes are never low together.
- R7: `done` lasts exactly one clock, occurs only in the last recovery clock, and both strobes are high while it is asserted.
- R8: A write with `cfg_class`=0 (PIO) replaces exactly the bits of mask 0xCFC3FFFF in the selected word.
- R9: A write with `cfg_class`=1 (multiword DMA) replaces exactly the bits of mask 0x31C001FF, so the data-cycle fields change and the task-file fields are kept.
- R10: A write with `cfg_class`=2 (ultra-DMA) replaces only the bits of mask 0x303C0000 and leaves all strobe timing unchanged.
- R11: A write with `cfg_class`=3 changes nothing.
- R12: `cfg_dev` selects the word that a write updates, and `req_dev` selects the word that a cycle uses; each device's word is independent.
- R13: The word is sampled when a cycle is accepted. A write that lands during a cycle affects only later cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dev | input | DEV_W | Device whose word is written |
| cfg_class | input | 2 | Transfer class: 0 PIO, 1 multiword DMA, 2 ultra-DMA, 3 none |
| cfg_wdata | input | 32 | Write data, merged under the class mask |
| req | input | 1 | Cycle request (level) |
| req_dev | input | DEV_W | Device addressed by the cycle |
| req_tf | input | 1 | 1 = task-file cycle, 0 = data cycle |
| req_wr | input | 1 | 1 = write strobe, 0 = read strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
Cycles are run from the reset word, from all-zero fields (every phase is one clock) and from all-ones fields (the longest phases). This separates a field decoded at the wrong position from an off-by-one phase count. Each class of masked write is followed by both a data cycle and a task-file cycle, so a wrong mask bit shows up as a changed phase length in exactly one kind of cycle. Fresh starts are run against back-to-back chains to tell the setup path apart from the handoff path. Alternating devices and a write that lands in the middle of a cycle separate a wrong word select from a word that is sampled too late.

// File: rtl/pata_strobe_pkg.sv
package pata_strobe_pkg;

    localparam int WORD_W  = 32;

    // field positions inside the packed timing word
    localparam int DREC_LSB = 0;
    localparam int DACT_LSB = 4;
    localparam int TREC_LSB = 9;
    localparam int TACT_LSB = 13;
    localparam int DSU_LSB  = 22;
    localparam int TSU_LSB  = 25;

    localparam int REC_W = 4;
    localparam int ACT_W = 5;
    localparam int SU_W  = 3;

    localparam logic [WORD_W-1:0] MASK_PIO   = 32'hCFC3_FFFF;
    localparam logic [WORD_W-1:0] MASK_MWDMA = 32'h31C0_01FF;
    localparam logic [WORD_W-1:0] MASK_UDMA  = 32'h303C_0000;

    typedef enum logic [1:0] {
        CLS_PIO   = 2'd0,
        CLS_MWDMA = 2'd1,
        CLS_UDMA  = 2'd2,
        CLS_NONE  = 2'd3
    } cfg_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_RECOVER,
        ST_HANDOFF
    } strobe_state_e;

    typedef struct packed {
        logic [SU_W-1:0]  setup;
        logic [ACT_W-1:0] active;
        logic [REC_W-1:0] recover;
    } phase_times_t;

    function automatic phase_times_t decode_times(input logic [WORD_W-1:0] w,
                                                  input logic tf);
        phase_times_t t;
        if (tf) begin
            t.setup   = w[TSU_LSB  +: SU_W];
            t.active  = w[TACT_LSB +: ACT_W];
            t.recover = w[TREC_LSB +: REC_W];
        end else begin
            t.setup   = w[DSU_LSB  +: SU_W];
            t.active  = w[DACT_LSB +: ACT_W];
            t.recover = w[DREC_LSB +: REC_W];
        end
        return t;
    endfunction

    function automatic logic [WORD_W-1:0] class_mask(input cfg_class_e c);
        logic [WORD_W-1:0] m;
        unique case (c)
            CLS_PIO:   m = MASK_PIO;
            CLS_MWDMA: m = MASK_MWDMA;
            CLS_UDMA:  m = MASK_UDMA;
            default:   m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pata_cfg_bank.sv
module pata_cfg_bank
    import pata_strobe_pkg::*;
#(
    parameter int                NUM_DEV    = 2,
    parameter int                DEV_W      = 1,
    parameter logic [WORD_W-1:0] RESET_WORD = 32'h0681_4EA7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [DEV_W-1:0]          wr_dev,
    input  logic [1:0]                wr_class,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic [DEV_W-1:0]          sel_dev,
    output logic [WORD_W-1:0]         sel_word,
    output logic [NUM_DEV*WORD_W-1:0] all_words
);

    logic [WORD_W-1:0] wmask;
    assign wmask = class_mask(cfg_class_e'(wr_class));

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= RESET_WORD;
            end else if (wr_en && (wr_dev == DEV_W'(g))) begin
                word_q <= (word_q & ~wmask) | (wr_data & wmask);
            end
        end
        assign all_words[g*WORD_W +: WORD_W] = word_q;
    end

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (sel_dev == DEV_W'(i)) begin
                sel_word = all_words[i*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/pata_strobe_fsm.sv
module pata_strobe_fsm
    import pata_strobe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_tf,
    input  logic              req_wr,
    input  logic [WORD_W-1:0] cfg_word,
    output logic              rd_n,
    output logic              wr_n,
    output logic              done,
    output strobe_state_e     phase
);

    localparam int AR_W  = (ACT_W > REC_W) ? ACT_W : REC_W;
    localparam int CNT_W = (AR_W > SU_W) ? AR_W : SU_W;

    strobe_state_e    state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    phase_times_t     lat_q, lat_d, in_t;
    logic             wr_q, wr_d;
    logic             last;

    assign in_t  = decode_times(cfg_word, req_tf);
    assign last  = (cnt_q == '0);
    assign phase = state_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lat_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lat_q   <= lat_d;
            wr_q    <= wr_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lat_d   = lat_q;
        wr_d    = wr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = ST_SETUP;
                    cnt_d   = CNT_W'(in_t.setup);
                    lat_d   = in_t;
                    wr_d    = req_wr;
                end
            end
            ST_SETUP: begin
                if (last) begin
                    state_d = ST_ACTIVE;
                    cnt_d   = CNT_W'(lat_q.active);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_ACTIVE: begin
                if (last) begin
                    state_d = ST_RECOVER;
                    cnt_d   = CNT_W'(lat_q.recover);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_RECOVER: begin
                if (last) begin
                    state_d = ST_HANDOFF;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_HANDOFF: begin
                if (req) begin
                    state_d = ST_ACTIVE;
                    cnt_d   = CNT_W'(in_t.active);
                    lat_d   = in_t;
                    wr_d    = req_wr;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_n = 1'b1;
        wr_n = 1'b1;
        done = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                if (wr_q) wr_n = 1'b0;
                else      rd_n = 1'b0;
            end
            ST_RECOVER: done = last;
            default: ;
        endcase
    end

endmodule

// File: rtl/pata_strobe_gen.sv
module pata_strobe_gen
    import pata_strobe_pkg::*;
#(
    parameter int          NUM_DEV    = 2,
    parameter int          DEV_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    parameter logic [31:0] RESET_WORD = 32'h0681_4EA7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [DEV_W-1:0] cfg_dev,
    input  logic [1:0]       cfg_class,
    input  logic [31:0]      cfg_wdata,
    input  logic             req,
    input  logic [DEV_W-1:0] req_dev,
    input  logic             req_tf,
    input  logic             req_wr,
    output logic             rd_n,
    output logic             wr_n,
    output logic             done
);

    logic [NUM_DEV*WORD_W-1:0] dev_words;
    logic [WORD_W-1:0]         cur_word;
    strobe_state_e             phase;

    pata_cfg_bank #(
        .NUM_DEV    (NUM_DEV),
        .DEV_W      (DEV_W),
        .RESET_WORD (RESET_WORD)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_dev    (cfg_dev),
        .wr_class  (cfg_class),
        .wr_data   (cfg_wdata),
        .sel_dev   (req_dev),
        .sel_word  (cur_word),
        .all_words (dev_words)
    );

    pata_strobe_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_tf   (req_tf),
        .req_wr   (req_wr),
        .cfg_word (cur_word),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .done     (done),
        .phase    (phase)
    );

endmodule

// File: rtl/pata_strobe_gen_chk.sv
module pata_strobe_gen_chk
    import pata_strobe_pkg::*;
#(
    parameter int NUM_DEV = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [1:0]                cfg_class,
    input logic                      req,
    input logic                      rd_n,
    input logic                      wr_n,
    input logic                      done,
    input strobe_state_e             phase,
    input logic [NUM_DEV*WORD_W-1:0] dev_words
);

    localparam logic [NUM_DEV*WORD_W-1:0] KEEP_UDMA = {NUM_DEV{~MASK_UDMA}};

    // R6
    excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R6
    active_one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_ACTIVE) |-> ($countones({rd_n, wr_n}) == 1));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_n && wr_n && phase == ST_RECOVER));

    // R5
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_HANDOFF && req) |=> (phase == ST_ACTIVE));

    // R10
    udma_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_class == 2'd2) |=>
            ((dev_words & KEEP_UDMA) == ($past(dev_words) & KEEP_UDMA)));

    // R11
    none_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_class == 2'd3) |=> $stable(dev_words));

endmodule

bind pata_strobe_gen pata_strobe_gen_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_class (cfg_class),
    .req       (req),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .done      (done),
    .phase     (phase),
    .dev_words (dev_words)
);

// File: tb/pata_strobe_gen_tb.sv
module pata_strobe_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_dev = '0;
    logic [1:0]  cfg_class = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req = 1'b0;
    logic [0:0]  req_dev = '0;
    logic        req_tf = 1'b0;
    logic        req_wr = 1'b0;
    logic        rd_n, wr_n, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        int    lead;
        int    act;
        int    rec;
        bit    wr;
        string tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] model[2];

    always #5 clk = ~clk;

    pata_strobe_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dev(cfg_dev),
        .cfg_class(cfg_class), .cfg_wdata(cfg_wdata), .req(req),
        .req_dev(req_dev), .req_tf(req_tf), .req_wr(req_wr),
        .rd_n(rd_n), .wr_n(wr_n), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int got, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    // masks per R8/R9/R10/R11
    function automatic logic [31:0] merge(input logic [31:0] old,
                                          input logic [1:0] cls,
                                          input logic [31:0] d);
        logic [31:0] m;
        case (cls)
            2'd0:    m = 32'hCFC3_FFFF;
            2'd1:    m = 32'h31C0_01FF;
            2'd2:    m = 32'h303C_0000;
            default: m = 32'h0;
        endcase
        return (old & ~m) | (d & m);
    endfunction

    task automatic cfg_write(input int dev, input logic [1:0] cls,
                             input logic [31:0] d);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_dev = 1'(dev); cfg_class = cls; cfg_wdata = d;
        model[dev] = merge(model[dev], cls, d);
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic do_cycle(input int dev, input bit tf, input bit wr,
                            input bit chained, input string tag);
        exp_t e;
        logic [31:0] w;
        w = model[dev];
        if (tf) begin
            e.act  = int'(w[17:13]) + 1;
            e.rec  = int'(w[12:9]) + 1;
            e.lead = chained ? 1 : int'(w[27:25]) + 2;
        end else begin
            e.act  = int'(w[8:4]) + 1;
            e.rec  = int'(w[3:0]) + 1;
            e.lead = chained ? 1 : int'(w[24:22]) + 2;
        end
        e.wr  = wr;
        e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk); #2;
        req_dev = 1'(dev); req_tf = tf; req_wr = wr; req = 1'b1;
        do @(negedge clk); while (!done);
    endtask

    task automatic end_burst();
        @(posedge clk); #2;
        req = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    // monitor / scoreboard
    int m_ph = 0, m_lead = 0, m_act = 0, m_rec = 0;
    bit m_wr = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_lead = 0;
        end else begin
            if (!rd_n && !wr_n) chk(0, "R6", "both strobes low", 1, 0);
            if (!rd_n || !wr_n) begin
                if (m_ph == 0) begin
                    m_ph = 1; m_act = 1; m_wr = !wr_n;
                end else if (m_ph == 1) begin
                    m_act++;
                end else begin
                    chk(0, "R7", "strobe low during recovery", 1, 0);
                end
            end else begin
                if (m_ph == 0) begin
                    if (req) m_lead++;
                end else if (m_ph == 1) begin
                    m_ph = 2; m_rec = 1;
                end else begin
                    m_rec++;
                end
            end
            if (done) begin
                if (m_ph != 2 || exp_q.size() == 0) begin
                    chk(0, "R7", "done outside recovery", m_ph, 2);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(m_lead == e.lead, e.tag, "lead clocks", m_lead, e.lead);
                    chk(m_act == e.act, e.tag, "active clocks", m_act, e.act);
                    chk(m_rec == e.rec, e.tag, "recovery clocks", m_rec, e.rec);
                    chk(m_wr == e.wr, {e.tag, "/R6"}, "write strobe used",
                        int'(m_wr), int'(e.wr));
                end
                m_ph = 0; m_lead = 0;
            end
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        model[0] = 32'h0681_4EA7;
        model[1] = 32'h0681_4EA7;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_n == 1'b1, "R1", "rd_n", int'(rd_n), 1);
        chk(wr_n == 1'b1, "R1", "wr_n", int'(wr_n), 1);
        chk(done == 1'b0, "R1", "done", int'(done), 0);

        // R1 R2 R4: reset word, data read from idle
        do_cycle(0, 0, 0, 0, "R1/R2/R4");
        end_burst();
        // R3 R4 R6: task-file write from idle
        do_cycle(0, 1, 1, 0, "R3/R4/R6");
        end_burst();

        // R8 R12: program device 1 only
        cfg_write(1, 2'd0, 32'h0641_4E31);
        do_cycle(1, 0, 0, 0, "R8/R12");
        do_cycle(0, 0, 1, 1, "R5/R12");
        end_burst();

        // R8 boundary: all fields zero
        cfg_write(0, 2'd0, 32'h0000_0000);
        do_cycle(0, 0, 0, 0, "R8");
        do_cycle(0, 1, 1, 1, "R5/R8");
        end_burst();

        // R8 boundary: all fields at maximum
        cfg_write(0, 2'd0, 32'hFFFF_FFFF);
        do_cycle(0, 1, 0, 0, "R8");
        do_cycle(0, 0, 0, 1, "R5/R8");
        end_burst();

        // R9: multiword DMA class clears data fields only
        cfg_write(0, 2'd1, 32'h0000_0000);
        do_cycle(0, 0, 1, 0, "R9");
        do_cycle(0, 1, 0, 1, "R9");
        end_burst();

        // R10: ultra-DMA class leaves strobe timing alone
        cfg_write(0, 2'd2, 32'h0000_0000);
        do_cycle(0, 1, 0, 0, "R10");
        do_cycle(0, 0, 1, 1, "R10");
        end_burst();

        // R11: class 3 writes nothing
        cfg_write(1, 2'd3, 32'h0000_0000);
        do_cycle(1, 0, 0, 0, "R11");
        do_cycle(1, 1, 1, 1, "R11");
        end_burst();

        // R13: write lands mid-cycle, used only by the next cycle
        fork
            do_cycle(1, 0, 0, 0, "R13");
            begin
                repeat (2) @(posedge clk);
                cfg_write(1, 2'd0, 32'h0000_0021);
            end
        join
        do_cycle(1, 0, 1, 1, "R13");
        end_burst();

        repeat (5) @(posedge clk);
        chk(exp_q.size() == 0, "R7", "cycles left unfinished", exp_q.size(), 0);
        finished = 1;
        summary();
        $finish;
    end

endmodule